// File: doc/BRIEF.md
# Reloadable Down-Counting Interval Timer

This block is a 16-bit interval timer. Its counter steps down by one on every enabled tick of a selected count source. When it underflows it takes the period value from a separate reload register and keeps running without software help. Each underflow also produces a one-cycle interrupt request pulse. The period is n + 1 ticks, where n is the programmed value.

Software reaches the timer through a small register port with a write strobe, an address, write data and a combinational read path. Address 0 takes the period value on a write and returns the live count on a read. Address 1 holds the run bit and the count-source selector. A write to address 0 loads both the reload register and the counter while the timer is stopped. While it is running, the same write changes only the reload register, and the counter picks up the new value at its next underflow.

The count source is one of five enables from a free-running prescaler (divide by 1, 2, 8, 32 or 64) or one of two external tick-enable inputs, so the whole timer runs on a single clock.

Top module: `ivl_timer`

## Requirements
- R1: While running, each enabled tick of the selected source with a nonzero count lowers the count by exactly one in the following cycle.
- R2: An enabled tick while the count is 0000h while running loads the counter from the reload register, and counting goes on without any software action.
- R3: With period value n (0000h to FFFFh), underflows are spaced n + 1 selected-source ticks apart. For a prescaled source with divide factor D this is (n + 1) * D clock cycles.
- R4: Bit 0 of the control register (address 1) is the run bit: 1 counts and 0 stops. While stopped, the count holds its value whatever happens on the tick inputs.
- R5: Each underflow drives `irq` high for exactly one clock cycle, which is the same cycle in which the reloaded count is first visible. With period 0 and a tick every cycle, `irq` stays high.
- R6: A write to address 0 while stopped sets both the reload register and the counter, and the new value reads back from address 0 in the next cycle.
- R7: A write to address 0 while running changes only the reload register. The count continues from its old value, and the written value appears in the counter at the next underflow, including an underflow in the same cycle as the write.
- R8: Control bits 6:4 select the count source: 0 = clock/1, 1 = clock/2, 2 = clock/8, 3 = clock/32, 4 = clock/64, 5 = `ext_tick_a`, 6 = `ext_tick_b`, 7 = no source. Tick inputs that are not selected have no effect on the count.
- R9: Address 1 reads back the run bit at bit 0 and the source code at bits 6:4, with zeros elsewhere. Addresses 2 and 3 read as zero, and writes to them change nothing.
- R10: After reset the timer is stopped, the count, reload value and source code are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| ext_tick_a | input | 1 | External tick enable, source code 5 |
| ext_tick_b | input | 1 | External tick enable, source code 6 |
| irq | output | 1 | One-cycle underflow interrupt request |

## Verification
A corrupted count shows up on the address 0 read in the cycle after the tick that caused it. It also shows up as a wrong spacing between `irq` pulses, at the latest at the next underflow. A reload register that takes a running write at the wrong time changes the count seen right after that write, or the value read just after the following underflow. A wrong prescaler phase or a swapped source decode changes the measured pulse spacing in the first full period after the source is selected.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int unsigned NUM_DIV = 5;
    localparam int unsigned PRE_W   = 6;

    typedef int unsigned div_log2_t [NUM_DIV];
    localparam div_log2_t DIV_LOG2 = '{0, 1, 3, 5, 6};

    typedef enum logic [2:0] {
        SRC_DIV1  = 3'd0,
        SRC_DIV2  = 3'd1,
        SRC_DIV8  = 3'd2,
        SRC_DIV32 = 3'd3,
        SRC_DIV64 = 3'd4,
        SRC_EXT_A = 3'd5,
        SRC_EXT_B = 3'd6,
        SRC_NONE  = 3'd7
    } src_sel_e;

    localparam logic [1:0] ADDR_COUNT = 2'd0;
    localparam logic [1:0] ADDR_CTRL  = 2'd1;

endpackage

// File: rtl/ivl_prescaler.sv
module ivl_prescaler
    import ivl_timer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_DIV-1:0] div_tick
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t pre_d, pre_q;

    always_comb begin
        pre_d     = pre_q;
        pre_d.cnt = pre_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    for (genvar g = 0; g < NUM_DIV; g++) begin : g_tap
        if (DIV_LOG2[g] == 0) begin : g_full
            assign div_tick[g] = 1'b1;
        end else begin : g_part
            assign div_tick[g] = &pre_q.cnt[DIV_LOG2[g]-1:0];
        end
    end

    // R8: the divide-by-two enable alternates
    assert_div2_alternates_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick[1] |=> !div_tick[1]);
    // R8: the divide-by-64 enable is never high two cycles in a row
    assert_div64_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick[4] |=> !div_tick[4]);

endmodule

// File: rtl/ivl_src_mux.sv
module ivl_src_mux
    import ivl_timer_pkg::*;
(
    input  logic [NUM_DIV-1:0] div_tick,
    input  logic               ext_a,
    input  logic               ext_b,
    input  src_sel_e           sel,
    output logic               tick
);

    always_comb begin
        unique case (sel)
            SRC_DIV1:  tick = div_tick[0];
            SRC_DIV2:  tick = div_tick[1];
            SRC_DIV8:  tick = div_tick[2];
            SRC_DIV32: tick = div_tick[3];
            SRC_DIV64: tick = div_tick[4];
            SRC_EXT_A: tick = ext_a;
            SRC_EXT_B: tick = ext_b;
            default:   tick = 1'b0;
        endcase
    end

endmodule

// File: rtl/ivl_ctrl_regs.sv
module ivl_ctrl_regs
    import ivl_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [1:0]        addr,
    input  logic              wdata_run,
    input  logic [2:0]        wdata_src,
    input  logic [DATA_W-1:0] count,
    output logic              run,
    output src_sel_e          src,
    output logic              wr_count,
    output logic [DATA_W-1:0] rdata
);

    typedef struct packed {
        logic     run;
        src_sel_e src;
    } ctrl_state_t;

    ctrl_state_t ctl_d, ctl_q;
    logic        wr_ctrl;

    assign wr_ctrl  = wen && (addr == ADDR_CTRL);
    assign wr_count = wen && (addr == ADDR_COUNT);

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctrl) begin
            ctl_d.run = wdata_run;
            ctl_d.src = src_sel_e'(wdata_src);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.run <= 1'b0;
            ctl_q.src <= SRC_DIV1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_COUNT) begin
            rdata = count;
        end else if (addr == ADDR_CTRL) begin
            rdata[0]   = ctl_q.run;
            rdata[6:4] = ctl_q.src;
        end
    end

    assign run = ctl_q.run;
    assign src = ctl_q.src;

    // R9: the control register moves only on a write to its own address
    assert_ctrl_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> ($stable(run) && $stable(src)));

endmodule

// File: rtl/ivl_down_core.sv
module ivl_down_core #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wr_count,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        logic             irq;
    } core_state_t;

    core_state_t st_d, st_q;
    logic        at_zero;

    assign at_zero = (st_q.cnt == '0);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_count) st_d.rel = wdata;
        if (!run) begin
            if (wr_count) st_d.cnt = wdata;
        end else if (tick) begin
            if (at_zero) begin
                st_d.cnt = st_d.rel;
                st_d.irq = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;
    assign irq   = st_q.irq;

    // R1: a running tick on a nonzero count steps down by one
    assert_step_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !at_zero) |=> (count == $past(count) - 1'b1));
    // R2: the count shown with the interrupt equals the reload value
    assert_reload_on_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == st_q.rel));
    // R4: stopped and not written, the count holds
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_count) |=> $stable(count));
    // R5: an interrupt only follows a zero count
    assert_irq_after_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(count) == '0));
    // R6: stopped write lands in the counter
    assert_stopped_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count && !run) |=> (count == $past(wdata)));
    // R7: running write without a tick leaves the count alone
    assert_run_write_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_count && run && !tick) |=> $stable(count));

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wen,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ext_tick_a,
    input  logic             ext_tick_b,
    output logic             irq
);

    logic [NUM_DIV-1:0] div_tick;
    logic               run;
    src_sel_e           src;
    logic               wr_count;
    logic               tick;
    logic [CNT_W-1:0]   count;

    ivl_prescaler i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_tick (div_tick)
    );

    ivl_src_mux i_mux (
        .div_tick (div_tick),
        .ext_a    (ext_tick_a),
        .ext_b    (ext_tick_b),
        .sel      (src),
        .tick     (tick)
    );

    ivl_ctrl_regs #(.DATA_W(CNT_W)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (bus_wen),
        .addr      (bus_addr),
        .wdata_run (bus_wdata[0]),
        .wdata_src (bus_wdata[6:4]),
        .count     (count),
        .run       (run),
        .src       (src),
        .wr_count  (wr_count),
        .rdata     (bus_rdata)
    );

    ivl_down_core #(.CNT_W(CNT_W)) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick),
        .wr_count (wr_count),
        .wdata    (bus_wdata),
        .count    (count),
        .irq      (irq)
    );

endmodule

// File: tb/test_ivl_timer.sv
module test_ivl_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ext_tick_a = 1'b0;
    logic        ext_tick_b = 1'b0;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    ivl_timer i_ivl_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wen    (bus_wen),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ext_tick_a (ext_tick_a),
        .ext_tick_b (ext_tick_b),
        .irq        (irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wen = 1'b0; bus_addr = 2'd0;
        #1;
    endtask

    task automatic bus_read(input logic [1:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
        bus_addr = 2'd0;
    endtask

    task automatic pulse(input bit which_b);
        @(negedge clk);
        if (which_b) ext_tick_b = 1'b1; else ext_tick_a = 1'b1;
        @(negedge clk);
        ext_tick_a = 1'b0; ext_tick_b = 1'b0;
        #1;
    endtask

    task automatic wait_irq_gap(output int gap);
        int guard = 0;
        while (!irq && guard < 10000) begin
            @(negedge clk); #1; guard++;
        end
        gap = 0;
        do begin
            @(negedge clk); #1; gap++;
        end while (!irq && gap < 10000);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int v;
        int gap;
        int divs [5] = '{1, 2, 8, 32, 64};
        int pers [4] = '{0, 1, 3, 6};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10 reset state
        bus_read(2'd0, v); check("R10 count", v, 0);
        bus_read(2'd1, v); check("R10 ctrl", v, 0);
        check("R10 irq", int'(irq), 0);

        // R6 stopped write
        bus_write(2'd0, 16'd5);
        bus_read(2'd0, v); check("R6 load", v, 5);

        // R8/R1 external source A, count down
        bus_write(2'd1, 16'h0051);
        for (int k = 1; k <= 5; k++) begin
            pulse(1'b0);
            bus_read(2'd0, v); check("R1 step", v, 5 - k);
        end
        pulse(1'b0);
        bus_read(2'd0, v); check("R2 reload", v, 5);
        check("R5 irq high", int'(irq), 1);
        @(negedge clk); #1;
        check("R5 irq one cycle", int'(irq), 0);

        // R8 unselected source ignored
        pulse(1'b1);
        bus_read(2'd0, v); check("R8 ext_b ignored", v, 5);

        // R7 running write only reaches reload
        bus_write(2'd0, 16'd2);
        bus_read(2'd0, v); check("R7 count untouched", v, 5);
        for (int k = 0; k < 6; k++) pulse(1'b0);
        bus_read(2'd0, v); check("R7 new reload", v, 2);
        check("R7 irq", int'(irq), 1);
        for (int k = 0; k < 3; k++) pulse(1'b0);
        check("R3 interval n+1", int'(irq), 1);

        // R4 stop holds count
        bus_write(2'd1, 16'h0050);
        bus_read(2'd0, v); check("R4 held value", v, 2);
        pulse(1'b0); pulse(1'b0);
        bus_read(2'd0, v); check("R4 stopped", v, 2);

        // R9 register map
        bus_read(2'd1, v); check("R9 ctrl readback", v, 16'h0050);
        bus_read(2'd2, v); check("R9 addr2 zero", v, 0);
        bus_write(2'd3, 16'hFFFF);
        bus_read(2'd1, v); check("R9 addr3 write ignored", v, 16'h0050);
        bus_read(2'd0, v); check("R9 addr3 count kept", v, 2);

        // R5 period zero: every tick underflows
        bus_write(2'd0, 16'd0);
        bus_write(2'd1, 16'h0051);
        for (int k = 0; k < 3; k++) begin
            pulse(1'b0);
            check("R5 period zero irq", int'(irq), 1);
            bus_read(2'd0, v); check("R2 period zero count", v, 0);
        end

        // R1 boundary FFFFh
        bus_write(2'd1, 16'h0050);
        bus_write(2'd0, 16'hFFFF);
        bus_read(2'd0, v); check("R6 max load", v, 16'hFFFF);
        bus_write(2'd1, 16'h0061);
        pulse(1'b0);
        bus_read(2'd0, v); check("R8 ext_a ignored under B", v, 16'hFFFF);
        pulse(1'b1);
        bus_read(2'd0, v); check("R1 max step", v, 16'hFFFE);

        // R8 code 7: no source
        bus_write(2'd1, 16'h0070);
        bus_write(2'd0, 16'd3);
        bus_write(2'd1, 16'h0071);
        repeat (200) @(negedge clk);
        pulse(1'b0); pulse(1'b1);
        #1;
        bus_read(2'd0, v); check("R8 no source", v, 3);

        // R3/R8 prescaled sources sweep
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 4; p++) begin
                bus_write(2'd1, 16'(s << 4));
                bus_write(2'd0, 16'(pers[p]));
                bus_write(2'd1, 16'((s << 4) | 1));
                wait_irq_gap(gap);
                wait_irq_gap(gap);
                check($sformatf("R3 src%0d n%0d gap", s, pers[p]), gap, (pers[p] + 1) * divs[s]);
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule